// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block holds the time of day and the calendar date as packed BCD bytes: seconds, minutes, hours, day of month, month, two-digit year and day of week. A 32.768 kHz clock-enable input is divided down to a once-per-second step. Each step advances the seconds. Carries then ripple through minutes, hours, date, month and year in the same clock cycle. The day of week advances together with the date.

The hour byte carries its own format bit. When that bit is set, the hour runs 00 to 23. When it is clear, the hour runs 12, 1 to 11, and a PM flag inside the same byte toggles each time the hour passes from 11 to 12. Month lengths and a leap year every fourth year value are applied. A signed trim code lengthens or shortens the count per second by a whole number of 20 ppm steps, and the remainder is carried as a fraction from one second to the next.

A register front end writes fields through a narrow load port, one byte per cycle. It marks the end of each write transaction with a done strobe. After reset the counter stays frozen until the first transaction that wrote at least one field completes. Each such completion restarts the one-second phase from zero.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds and minutes count 00 to 59 in BCD. Each wraps to 00 and carries into the next field.
- R2: When hour bit 7 is 1, the hour counts 00 to 23 in bits 5:0, wraps to 00 with a carry into the date, and bit 7 keeps its value.
- R3: When hour bit 7 is 0, hour bits 4:0 run 12, 01 to 11, and bit 5 is the PM flag (1 = PM). The flag toggles on the step from 11 to 12, and only the step from 11 PM to 12 AM carries into the date.
- R4: The date counts from 01 up to the length of the month. Months 04, 06, 09 and 11 have 30 days, February is covered by R5, and every other month value has 31 days. After the last day the date becomes 01 and the month advances.
- R5: February has 29 days when the year value is divisible by 4, including 00, and 28 days otherwise.
- R6: The month counts 01 to 12 and then returns to 01 with a carry into the year. The year counts 00 to 99 and then wraps to 00.
- R7: The day of week counts 0 to 6, wraps to 0, and advances exactly when the date advances.
- R8: Reset clears every field to 00h and clears `running_o`. No step occurs, and no field changes except by a load, until a write transaction completes.
- R9: A `ld_done_i` strobe restarts the second phase only if at least one load (`ld_valid_i`) occurred since the previous strobe. The first step then comes after exactly TICKS_PER_SEC tick enables. A strobe with no load has no effect.
- R10: Trim code `trim_i`: bit 2 is the sign (0 = faster, 1 = slower) and bits 1:0 are the magnitude in 20 ppm steps. Over time the counts per second average TICKS_PER_SEC*(1 ∓ 20e-6*mag). Codes 000 and 100 give exactly TICKS_PER_SEC counts per second.
- R11: A carry that ripples across several fields updates all of them in the same clock cycle, one cycle after `sec_pulse_o`.
- R12: A loaded byte is stored as written, even when it is out of range. On the next increment, any value at or above the field's maximum becomes the field's minimum and produces a carry.
- R13: `ld_sel_i` selects the field: 0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 year, 6 day of week. Value 7 writes nothing. A load takes priority over an increment of the same field in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset (total loss of state) |
| tick_en_i | input | 1 | 32.768 kHz clock enable |
| trim_i | input | 3 | Signed trim code |
| ld_valid_i | input | 1 | Load strobe for one field |
| ld_sel_i | input | 3 | Field selector for the load |
| ld_data_i | input | 8 | Byte to store |
| ld_done_i | input | 1 | End of a write transaction |
| sec_o | output | 8 | Seconds, BCD |
| min_o | output | 8 | Minutes, BCD |
| hour_o | output | 8 | Hour byte with format and PM bits |
| date_o | output | 8 | Day of month, BCD |
| month_o | output | 8 | Month, BCD |
| year_o | output | 8 | Year, BCD |
| dow_o | output | 8 | Day of week |
| running_o | output | 1 | Counting enabled |
| sec_pulse_o | output | 1 | One-cycle pulse per elapsed second |

## Verification
The embedded properties check the following on every cycle: fields stay frozen between steps and loads, the hour format bit survives increments, the PM flag flips on 11 to 12, the day of week and date wrap to their minimums, the prescaler count stays below its limit, the limit stays inside the trim band, and no pulse occurs while frozen. The bench scenarios are needed for behaviour a single cycle cannot show. These are the month and leap-year tables, the exact delay from a write completion to the first step, the averaged trim rates over several seconds, the wrapping of out-of-range loads, and that a multi-field rollover appears all at once.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;

    typedef logic [7:0] bcd8_t;

    localparam int NUM_FIELDS = 7;

    typedef enum logic [2:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_YEAR  = 3'd5,
        FLD_DOW   = 3'd6,
        FLD_NONE  = 3'd7
    } field_e;

    typedef struct packed {
        bcd8_t val;
        logic  wrap;
    } bcd_inc_t;

    // Increment a BCD byte; at or above hi it returns lo with wrap set.
    function automatic bcd_inc_t bcd_next(bcd8_t v, bcd8_t hi, bcd8_t lo);
        bcd_inc_t r;
        r.wrap = 1'b0;
        if (v >= hi) begin
            r.val  = lo;
            r.wrap = 1'b1;
        end else if (v[3:0] >= 4'd9) begin
            r.val = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r.val = v + 8'd1;
        end
        return r;
    endfunction

    // BCD year divisible by four: even tens take 0/4/8, odd tens take 2/6.
    function automatic logic is_leap(bcd8_t y);
        if (!y[4]) return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
        return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    endfunction

    function automatic bcd8_t month_days(bcd8_t m, bcd8_t y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
module cal_prescaler #(
    parameter int TICKS_PER_SEC = 32768,
    parameter int TRIM_STEP_PPM = 20,
    parameter int TRIM_DENOM    = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       tick_i,
    input  logic       restart_i,
    input  logic [2:0] trim_i,
    output logic       pulse_o
);
    localparam int MAX_INC = 3 * TRIM_STEP_PPM * TICKS_PER_SEC;
    localparam int MAX_ADJ = MAX_INC / TRIM_DENOM + 1;
    localparam int ACC_W   = $clog2(TRIM_DENOM + MAX_INC + 1) + 1;
    localparam int LIM_W   = $clog2(TICKS_PER_SEC + MAX_ADJ + 1) + 1;
    localparam int AW      = $clog2(MAX_ADJ + 1) + 1;

    localparam logic [ACC_W-1:0] INC1  = ACC_W'(TRIM_STEP_PPM * TICKS_PER_SEC);
    localparam logic [ACC_W-1:0] DEN   = ACC_W'(TRIM_DENOM);
    localparam logic [LIM_W-1:0] BASE  = LIM_W'(TICKS_PER_SEC);
    localparam logic [LIM_W-1:0] LOW_L = LIM_W'(TICKS_PER_SEC - MAX_ADJ);
    localparam logic [LIM_W-1:0] HI_L  = LIM_W'(TICKS_PER_SEC + MAX_ADJ);

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
        logic [LIM_W-1:0] limit;
        logic [ACC_W-1:0] acc;
        logic             pulse;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [ACC_W-1:0] inc_w;
    logic [ACC_W-1:0] frac_w;
    logic [AW-1:0]    adj_w;

    always_comb begin
        case (trim_i[1:0])
            2'd0:    inc_w = '0;
            2'd1:    inc_w = INC1;
            2'd2:    inc_w = INC1 << 1;
            default: inc_w = INC1 + (INC1 << 1);
        endcase
        frac_w = st_q.acc + inc_w;
        adj_w  = '0;
        for (int i = 0; i < MAX_ADJ; i++) begin
            if (frac_w >= DEN) begin
                frac_w = frac_w - DEN;
                adj_w  = adj_w + AW'(1);
            end
        end

        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (restart_i) begin
            st_d.cnt   = '0;
            st_d.acc   = '0;
            st_d.limit = BASE;
        end else if (run_i && tick_i) begin
            if (st_q.cnt >= st_q.limit - LIM_W'(1)) begin
                st_d.cnt   = '0;
                st_d.pulse = 1'b1;
                st_d.acc   = frac_w;
                st_d.limit = trim_i[2] ? BASE + LIM_W'(adj_w) : BASE - LIM_W'(adj_w);
            end else begin
                st_d.cnt = st_q.cnt + LIM_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.limit <= BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign pulse_o = st_q.pulse;

    AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.limit); // R9
    AST_LIMIT_IN_BAND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.limit >= LOW_L) && (st_q.limit <= HI_L)); // R10
    AST_NO_TRIM_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && !restart_i && trim_i[1:0] == 2'd0
         && st_q.cnt == st_q.limit - LIM_W'(1)) |=> (st_q.limit == BASE)); // R10
    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(run_i && tick_i && !restart_i)); // R8

endmodule

// File: rtl/cal_time.sv
module cal_time
    import bcd_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_i,
    input  logic [2:0] ld_en_i,
    input  bcd8_t      ld_data_i,
    output bcd8_t      sec_o,
    output bcd8_t      min_o,
    output bcd8_t      hour_o,
    output logic       day_carry_o
);
    typedef struct packed {
        bcd8_t sec;
        bcd8_t min;
        bcd8_t hour;
    } time_state_t;

    time_state_t st_d, st_q;
    bcd_inc_t    s_inc, m_inc, h_inc;
    bcd8_t       hour_nx;
    logic        hour_wrap;
    logic        pm_flip;

    always_comb begin
        s_inc = bcd_next(st_q.sec, 8'h59, 8'h00);
        m_inc = bcd_next(st_q.min, 8'h59, 8'h00);
        if (st_q.hour[7]) begin
            h_inc     = bcd_next({2'b00, st_q.hour[5:0]}, 8'h23, 8'h00);
            pm_flip   = 1'b0;
            hour_wrap = h_inc.wrap;
            hour_nx   = {st_q.hour[7:6], h_inc.val[5:0]};
        end else begin
            h_inc     = bcd_next({3'b000, st_q.hour[4:0]}, 8'h12, 8'h01);
            pm_flip   = !h_inc.wrap && (h_inc.val == 8'h12);
            hour_wrap = pm_flip && st_q.hour[5];
            hour_nx   = {st_q.hour[7:6], st_q.hour[5] ^ pm_flip, h_inc.val[4:0]};
        end

        st_d = st_q;
        if (step_i) begin
            st_d.sec = s_inc.val;
            if (s_inc.wrap) begin
                st_d.min = m_inc.val;
                if (m_inc.wrap) st_d.hour = hour_nx;
            end
        end
        if (ld_en_i[0]) st_d.sec  = ld_data_i;
        if (ld_en_i[1]) st_d.min  = ld_data_i;
        if (ld_en_i[2]) st_d.hour = ld_data_i;

        day_carry_o = step_i && s_inc.wrap && m_inc.wrap && hour_wrap;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sec_o  = st_q.sec;
    assign min_o  = st_q.min;
    assign hour_o = st_q.hour;

    AST_TIME_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && ld_en_i == 3'b000) |=> ($stable(sec_o) && $stable(min_o) && $stable(hour_o))); // R8
    AST_SEC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ld_en_i == 3'b000 && sec_o == 8'h59) |=> (sec_o == 8'h00)); // R1
    AST_FORMAT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ld_en_i == 3'b000) |=> (hour_o[7] == $past(hour_o[7]))); // R2
    AST_PM_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && ld_en_i == 3'b000 && !hour_o[7] && hour_o[4:0] == 5'h11
         && sec_o == 8'h59 && min_o == 8'h59) |=> (hour_o[5] != $past(hour_o[5]))); // R3

endmodule

// File: rtl/cal_date.sv
module cal_date
    import bcd_cal_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       day_inc_i,
    input  logic [3:0] ld_en_i,
    input  bcd8_t      ld_data_i,
    output bcd8_t      date_o,
    output bcd8_t      month_o,
    output bcd8_t      year_o,
    output bcd8_t      dow_o
);
    typedef struct packed {
        bcd8_t date;
        bcd8_t month;
        bcd8_t year;
        bcd8_t dow;
    } date_state_t;

    date_state_t st_d, st_q;
    bcd_inc_t    d_inc, m_inc, y_inc, w_inc;
    bcd8_t       last_day;

    always_comb begin
        last_day = month_days(st_q.month, st_q.year);
        d_inc    = bcd_next(st_q.date,  last_day, 8'h01);
        m_inc    = bcd_next(st_q.month, 8'h12,    8'h01);
        y_inc    = bcd_next(st_q.year,  8'h99,    8'h00);
        w_inc    = bcd_next(st_q.dow,   8'h06,    8'h00);

        st_d = st_q;
        if (day_inc_i) begin
            st_d.date = d_inc.val;
            st_d.dow  = w_inc.val;
            if (d_inc.wrap) begin
                st_d.month = m_inc.val;
                if (m_inc.wrap) st_d.year = y_inc.val;
            end
        end
        if (ld_en_i[0]) st_d.date  = ld_data_i;
        if (ld_en_i[1]) st_d.month = ld_data_i;
        if (ld_en_i[2]) st_d.year  = ld_data_i;
        if (ld_en_i[3]) st_d.dow   = ld_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign date_o  = st_q.date;
    assign month_o = st_q.month;
    assign year_o  = st_q.year;
    assign dow_o   = st_q.dow;

    AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (day_inc_i && ld_en_i == 4'b0000 && dow_o == 8'h06) |=> (dow_o == 8'h00)); // R7
    AST_DATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (day_inc_i && ld_en_i == 4'b0000) |=> (date_o != 8'h00)); // R4
    AST_MONTH_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (day_inc_i && ld_en_i == 4'b0000 && month_o != 8'h00) |=> (month_o != 8'h00)); // R6
    AST_DATE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!day_inc_i && ld_en_i == 4'b0000) |=> ($stable(date_o) && $stable(month_o)
                                              && $stable(year_o) && $stable(dow_o))); // R11

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
    import bcd_cal_pkg::*;
#(
    parameter int TICKS_PER_SEC = 32768,
    parameter int TRIM_STEP_PPM = 20,
    parameter int TRIM_DENOM    = 1000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en_i,
    input  logic [2:0] trim_i,
    input  logic       ld_valid_i,
    input  logic [2:0] ld_sel_i,
    input  logic [7:0] ld_data_i,
    input  logic       ld_done_i,
    output logic [7:0] sec_o,
    output logic [7:0] min_o,
    output logic [7:0] hour_o,
    output logic [7:0] date_o,
    output logic [7:0] month_o,
    output logic [7:0] year_o,
    output logic [7:0] dow_o,
    output logic       running_o,
    output logic       sec_pulse_o
);
    typedef struct packed {
        logic running;
        logic pending;
    } ctl_state_t;

    ctl_state_t ctl_d, ctl_q;
    logic       restart;
    logic [NUM_FIELDS-1:0] fld_ld;
    logic       day_carry;

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_ld
        assign fld_ld[g] = ld_valid_i && (ld_sel_i == 3'(g));
    end

    always_comb begin
        ctl_d   = ctl_q;
        restart = 1'b0;
        if (ld_valid_i) ctl_d.pending = 1'b1;
        if (ld_done_i) begin
            restart       = ctl_q.pending || ld_valid_i;
            ctl_d.pending = 1'b0;
            ctl_d.running = ctl_q.running || restart;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    cal_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC),
        .TRIM_STEP_PPM (TRIM_STEP_PPM),
        .TRIM_DENOM    (TRIM_DENOM)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctl_q.running),
        .tick_i    (tick_en_i),
        .restart_i (restart),
        .trim_i    (trim_i),
        .pulse_o   (sec_pulse_o)
    );

    cal_time u_time (
        .clk         (clk),
        .rst_n       (rst_n),
        .step_i      (sec_pulse_o),
        .ld_en_i     (fld_ld[2:0]),
        .ld_data_i   (ld_data_i),
        .sec_o       (sec_o),
        .min_o       (min_o),
        .hour_o      (hour_o),
        .day_carry_o (day_carry)
    );

    cal_date u_date (
        .clk       (clk),
        .rst_n     (rst_n),
        .day_inc_i (day_carry),
        .ld_en_i   (fld_ld[6:3]),
        .ld_data_i (ld_data_i),
        .date_o    (date_o),
        .month_o   (month_o),
        .year_o    (year_o),
        .dow_o     (dow_o)
    );

    assign running_o = ctl_q.running;

    AST_FROZEN_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !running_o |-> !sec_pulse_o); // R8
    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!sec_pulse_o && running_o)); // R9
    AST_DONE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_done_i && !ld_valid_i && !ctl_q.pending) |=> (running_o == $past(running_o))); // R9

endmodule

// File: tb/tb_bcd_calendar.sv
module tb_bcd_calendar;
    localparam int TICKS = 16;
    localparam int NV    = 21;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] trim = 3'd0;
    logic       ld_valid = 1'b0;
    logic [2:0] ld_sel = 3'd0;
    logic [7:0] ld_data = 8'h00;
    logic       ld_done = 1'b0;
    logic [7:0] sec, mnt, hour, date, month, year, dow;
    logic       running, pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    bcd_calendar #(.TICKS_PER_SEC(TICKS), .TRIM_STEP_PPM(20), .TRIM_DENOM(640)) dut (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en), .trim_i(trim),
        .ld_valid_i(ld_valid), .ld_sel_i(ld_sel), .ld_data_i(ld_data), .ld_done_i(ld_done),
        .sec_o(sec), .min_o(mnt), .hour_o(hour), .date_o(date), .month_o(month),
        .year_o(year), .dow_o(dow), .running_o(running), .sec_pulse_o(pulse)
    );

    // {sec,min,hour,date,month,year,dow} loaded, then expected one second later
    localparam logic [111:0] VEC [NV] = '{
        {56'h59_59_A3_31_12_99_06, 56'h00_00_80_01_01_00_00}, // R1 R2 R6 R7 R11 full rollover
        {56'h05_10_92_15_06_23_02, 56'h06_10_92_15_06_23_02}, // R1 plain step
        {56'h59_59_11_10_03_24_01, 56'h00_00_32_10_03_24_01}, // R3 11 AM -> 12 PM
        {56'h59_59_31_10_03_24_01, 56'h00_00_12_11_03_24_02}, // R3 11 PM -> 12 AM, day carry
        {56'h59_59_12_10_03_24_01, 56'h00_00_01_10_03_24_01}, // R3 12 -> 1
        {56'h59_59_32_10_03_24_01, 56'h00_00_21_10_03_24_01}, // R3 12 PM -> 1 PM
        {56'h59_59_09_10_03_24_01, 56'h00_00_10_10_03_24_01}, // R3 BCD carry 9 -> 10
        {56'h59_59_A3_30_04_24_03, 56'h00_00_80_01_05_24_04}, // R4 30-day month
        {56'h59_59_A3_31_01_24_03, 56'h00_00_80_01_02_24_04}, // R4 31-day month
        {56'h59_59_A3_30_09_24_02, 56'h00_00_80_01_10_24_03}, // R4 month 09 -> 10
        {56'h59_59_A3_28_02_24_00, 56'h00_00_80_29_02_24_01}, // R5 leap 24
        {56'h59_59_A3_29_02_24_00, 56'h00_00_80_01_03_24_01}, // R5 leap end
        {56'h59_59_A3_28_02_23_00, 56'h00_00_80_01_03_23_01}, // R5 common year
        {56'h59_59_A3_28_02_00_00, 56'h00_00_80_29_02_00_01}, // R5 year 00 is leap
        {56'h59_59_A3_28_02_10_00, 56'h00_00_80_01_03_10_01}, // R5 year 10 common
        {56'h59_59_A3_28_02_12_00, 56'h00_00_80_29_02_12_01}, // R5 year 12 leap
        {56'h59_59_A3_30_06_24_06, 56'h00_00_80_01_07_24_00}, // R4 R7 dow wrap
        {56'h75_10_A0_05_05_05_05, 56'h00_11_A0_05_05_05_05}, // R12 seconds out of range
        {56'h59_65_A0_05_05_05_05, 56'h00_00_A1_05_05_05_05}, // R12 minutes out of range
        {56'h59_59_A3_35_01_05_05, 56'h00_00_80_01_02_05_06}, // R12 date out of range
        {56'h59_59_A3_31_13_05_05, 56'h00_00_80_01_01_06_06}  // R12 R6 month out of range
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic load_fields(input logic [55:0] v);
        tick_en = 1'b0;
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            ld_valid = 1'b1;
            ld_sel   = 3'(k);
            ld_data  = v[55-8*k -: 8];
        end
        @(negedge clk);
        ld_valid = 1'b0;
        ld_done  = 1'b1;
        tick_en  = 1'b1;
        @(negedge clk);
        ld_done  = 1'b0;
    endtask

    task automatic wait_pulse(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pulse && n < 200);
    endtask

    function automatic logic [55:0] fields();
        return {sec, mnt, hour, date, month, year, dow};
    endfunction

    task automatic trim_run(input logic [2:0] code, input int exp_sum, input string tag);
        int n, sum;
        trim = code;
        load_fields(56'h00_00_80_01_01_00_00);
        wait_pulse(n);
        sum = 0;
        for (int k = 0; k < 4; k++) begin
            wait_pulse(n);
            sum += n;
        end
        check(sum == exp_sum, tag, 64'(sum), 64'(exp_sum));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", cyc, 150000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        repeat (3) @(negedge clk);
        // R8 reset state
        check(fields() == 56'h0 && !running, "R8 reset", {7'b0, running, fields()}, 64'h0);
        rst_n = 1'b1;
        tick_en = 1'b1;
        seen = 1'b0;
        for (int k = 0; k < 3 * TICKS; k++) begin
            @(negedge clk);
            if (pulse) seen = 1'b1;
        end
        check(!seen && sec == 8'h00, "R8 frozen after reset", {seen, sec}, 64'h0);
        // R9 done without a load does nothing
        @(negedge clk); ld_done = 1'b1;
        @(negedge clk); ld_done = 1'b0;
        repeat (2 * TICKS) @(negedge clk);
        check(!running && sec == 8'h00, "R9 empty done ignored", {running, sec}, 64'h0);
        // R13 select 7 writes nothing
        @(negedge clk); ld_valid = 1'b1; ld_sel = 3'd7; ld_data = 8'h42;
        @(negedge clk); ld_valid = 1'b0;
        check(fields() == 56'h0, "R13 select 7 ignored", fields(), 64'h0);
        // R9 first write starts counting; first step after TICKS enables
        load_fields(56'h10_00_80_01_01_00_00);
        check(running, "R8 running after write", 64'(running), 64'h1);
        wait_pulse(n);
        check(n == TICKS, "R9 phase restart", 64'(n), 64'(TICKS));
        @(negedge clk);
        check(sec == 8'h11, "R1 first step", sec, 64'h11);
        // main vector table
        for (int i = 0; i < NV; i++) begin
            load_fields(VEC[i][111:56]);
            wait_pulse(n);
            if (i == 0)
                check(fields() == VEC[0][111:56], "R11 no early partial update", fields(), VEC[0][111:56]);
            @(negedge clk);
            check(fields() == VEC[i][55:0], $sformatf("vector %0d", i), fields(), VEC[i][55:0]);
        end
        // R13 load beats increment on the same field
        load_fields(56'h20_00_80_01_01_00_00);
        tick_en = 1'b1;
        do @(negedge clk); while (!pulse);
        ld_valid = 1'b1; ld_sel = 3'd0; ld_data = 8'h45;
        @(negedge clk);
        ld_valid = 1'b0;
        check(sec == 8'h45, "R13 load priority", sec, 64'h45);
        // R10 trim averages over seconds 2..5
        trim_run(3'b000, 4 * TICKS, "R10 code 000");
        trim_run(3'b100, 4 * TICKS, "R10 code 100");
        trim_run(3'b001, 62, "R10 fast one step");
        trim_run(3'b011, 58, "R10 fast three steps");
        trim_run(3'b110, 68, "R10 slow two steps");
        trim = 3'b000;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule